// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block does the data arithmetic for a small accumulator-based processor. Each cycle in which `in_valid` is high, it takes an operation code, a register-side operand (the accumulator or an index register), a memory-side operand and the current status flags. It works out an 8-bit result and the new flag values. It covers bitwise combining, binary add and subtract with carry, compares, bit test, increment and decrement, and one-position shifts and rotates. The result and the flags are computed combinationally and are then captured in one register stage. The core reads everything it needs from that stage one cycle later.

Each operation updates its own fixed group of flags. Alongside each new flag value the block gives a per-flag enable, so the core can write the flags back without knowing the operation. A flag whose enable is low holds the incoming value, so a core that copies all four outputs every time also gets the right result. Compare and bit test update flags but do not request a result write. Shifts and rotates always send the bit that falls out into carry. Arithmetic is binary only: the decimal flag is accepted and has no effect.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first valid operation, `out_res`, `out_we`, all four flag outputs and all four flag enables are 0.
- R2: The outputs for an operation sampled with `in_valid` high on a rising clock edge appear after that edge. After an edge where `in_valid` was low, `out_we` and all flag enables are 0.
- R3: Operation codes 0 (OR), 1 (AND) and 2 (XOR) combine `opnd_a` with `opnd_m`. They write the result and enable only N (result bit 7) and Z (result is zero).
- R4: Code 3 (add with carry) writes `opnd_a + opnd_m + flag_c`. C is the carry out of bit 7. V is set when the signed sum falls outside -128..127. N and Z follow the result, and all four flags are enabled.
- R5: Code 4 (subtract with carry) writes `opnd_a + ~opnd_m + flag_c`. C is the carry out, meaning no borrow. V is set when the signed difference a - m - (1 - C) falls outside -128..127. All four flags are enabled.
- R6: Code 5 (compare) forms `opnd_a - opnd_m` and does not write. C is set when `opnd_a >= opnd_m` unsigned, N and Z follow the difference, and V is not enabled.
- R7: Code 6 (bit test) does not write. N takes `opnd_m` bit 7, V takes `opnd_m` bit 6, Z is set when `opnd_a & opnd_m` is zero, and C is not enabled.
- R8: Codes 7 (increment) and 8 (decrement) write `opnd_m + 1` and `opnd_m - 1` with wraparound, and enable only N and Z.
- R9: Code 9 (shift left) and code 10 (logical shift right) move `opnd_m` by one position and fill the vacated bit with 0. C takes the bit shifted out, and N, Z and C are enabled.
- R10: Code 11 (rotate left) and code 12 (rotate right) fill the vacated bit with the incoming `flag_c`. C takes the bit shifted out, and N, Z and C are enabled.
- R11: Every flag output whose enable is 0 equals the value of that flag's input sampled with the operation.
- R12: `flag_d` has no effect on any output.
- R13: Codes 13, 14 and 15 do not write and enable no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see R3 to R13) |
| opnd_a | input | WIDTH | Register-side operand (accumulator or index) |
| opnd_m | input | WIDTH | Memory-side operand, also the single operand of inc/dec/shift/rotate |
| flag_n | input | 1 | Current negative flag |
| flag_v | input | 1 | Current overflow flag |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| flag_d | input | 1 | Current decimal flag (ignored) |
| out_res | output | WIDTH | Registered result |
| out_we | output | 1 | Result should be written back |
| out_n | output | 1 | Next negative flag |
| out_v | output | 1 | Next overflow flag |
| out_z | output | 1 | Next zero flag |
| out_c | output | 1 | Next carry flag |
| en_n | output | 1 | Negative flag update enable |
| en_v | output | 1 | Overflow flag update enable |
| en_z | output | 1 | Zero flag update enable |
| en_c | output | 1 | Carry flag update enable |

## Verification
The only internal state is the output register stage, so a wrong capture shows at the ports in the cycle right after the operation. A stale stage shows as a nonzero enable or write after an idle cycle. A wrongly routed adder operand or carry-in shows as a wrong result or carry for a single operand pair. The corner values 0x00, 0x7F, 0x80 and 0xFF, each with carry 0 and 1, separate nearly all of these wrong routings. Flags without an enable are compared against the inputs on every operation, so a flag that leaks into the wrong group is caught on its first use.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_OR  = 4'd0,
      OP_AND = 4'd1,
      OP_XOR = 4'd2,
      OP_ADC = 4'd3,
      OP_SBC = 4'd4,
      OP_CMP = 4'd5,
      OP_BIT = 4'd6,
      OP_INC = 4'd7,
      OP_DEC = 4'd8,
      OP_ASL = 4'd9,
      OP_LSR = 4'd10,
      OP_ROL = 4'd11,
      OP_ROR = 4'd12
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } flag_set_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ carry[i];
            assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
         end
         assign cout = carry[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[MSB:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

   // Signed overflow: operands agree in sign, sum disagrees.
   assign ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] m,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output logic             cout
);

   localparam int MSB = WIDTH - 1;

   logic fill_lo;
   logic fill_hi;

   // Rotates bring carry into the vacated bit; plain shifts bring in zero.
   assign fill_lo = (op == OP_ROL) ? cin : 1'b0;
   assign fill_hi = (op == OP_ROR) ? cin : 1'b0;

   always_comb begin
      res  = '0;
      cout = 1'b0;
      unique case (op)
         OP_OR:          res = a | m;
         OP_AND, OP_BIT: res = a & m;
         OP_XOR:         res = a ^ m;
         OP_ASL, OP_ROL: begin
            res  = {m[MSB-1:0], fill_lo};
            cout = m[MSB];
         end
         OP_LSR, OP_ROR: begin
            res  = {fill_hi, m[MSB:1]};
            cout = m[0];
         end
         default: begin
            res  = '0;
            cout = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/acc_alu_stage.sv
module acc_alu_stage
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [WIDTH-1:0] res_d,
   input  logic             we_d,
   input  flag_set_t        flg_d,
   input  flag_set_t        en_d,
   output logic [WIDTH-1:0] res_q,
   output logic             we_q,
   output flag_set_t        flg_q,
   output flag_set_t        en_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         we_q  <= 1'b0;
         flg_q <= '0;
         en_q  <= '0;
      end else if (vld) begin
         res_q <= res_d;
         we_q  <= we_d;
         flg_q <= flg_d;
         en_q  <= en_d;
      end else begin
         we_q  <= 1'b0;
         en_q  <= '0;
      end
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_m,
   input  logic             flag_n,
   input  logic             flag_v,
   input  logic             flag_z,
   input  logic             flag_c,
   input  logic             flag_d,
   output logic [WIDTH-1:0] out_res,
   output logic             out_we,
   output logic             out_n,
   output logic             out_v,
   output logic             out_z,
   output logic             out_c,
   output logic             en_n,
   output logic             en_v,
   output logic             en_z,
   output logic             en_c
);

   localparam int MSB     = WIDTH - 1;
   localparam int TESTBIT = WIDTH - 2;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op_e;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_ci;
   logic [WIDTH-1:0] add_sum;
   logic             add_co;
   logic             add_ov;
   logic [WIDTH-1:0] bit_res;
   logic             bit_co;
   logic [WIDTH-1:0] res_d;
   logic             we_d;
   flag_set_t        flg_in;
   flag_set_t        flg_d;
   flag_set_t        en_d;
   flag_set_t        flg_q;
   flag_set_t        en_q;

   assign op_e   = alu_op_e'(op);
   assign flg_in = '{n: flag_n, v: flag_v, z: flag_z, c: flag_c};

   // Adder operand routing: one adder serves add, subtract, compare, inc, dec.
   always_comb begin
      add_x  = opnd_a;
      add_y  = opnd_m;
      add_ci = flag_c;
      case (op_e)
         OP_SBC: add_y = ~opnd_m;
         OP_CMP: begin
            add_y  = ~opnd_m;
            add_ci = 1'b1;
         end
         OP_INC: begin
            add_x  = opnd_m;
            add_y  = '0;
            add_ci = 1'b1;
         end
         OP_DEC: begin
            add_x  = opnd_m;
            add_y  = '1;
            add_ci = 1'b0;
         end
         default: ;
      endcase
   end

   acc_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_ci),
      .sum  (add_sum),
      .cout (add_co),
      .ovf  (add_ov)
   );

   acc_alu_bitops #(.WIDTH(WIDTH)) u_bitops (
      .op   (op_e),
      .a    (opnd_a),
      .m    (opnd_m),
      .cin  (flag_c),
      .res  (bit_res),
      .cout (bit_co)
   );

   // Per-operation result selection and flag group.
   always_comb begin
      res_d = '0;
      we_d  = 1'b0;
      flg_d = flg_in;
      en_d  = '0;
      case (op_e)
         OP_OR, OP_AND, OP_XOR: begin
            res_d   = bit_res;
            we_d    = 1'b1;
            flg_d.n = bit_res[MSB];
            flg_d.z = (bit_res == '0);
            en_d    = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
         end
         OP_ADC, OP_SBC: begin
            res_d   = add_sum;
            we_d    = 1'b1;
            flg_d   = '{n: add_sum[MSB], v: add_ov, z: (add_sum == '0), c: add_co};
            en_d    = '1;
         end
         OP_CMP: begin
            res_d   = add_sum;
            flg_d.n = add_sum[MSB];
            flg_d.z = (add_sum == '0);
            flg_d.c = add_co;
            en_d    = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
         end
         OP_BIT: begin
            res_d   = bit_res;
            flg_d.n = opnd_m[MSB];
            flg_d.v = opnd_m[TESTBIT];
            flg_d.z = (bit_res == '0);
            en_d    = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
         end
         OP_INC, OP_DEC: begin
            res_d   = add_sum;
            we_d    = 1'b1;
            flg_d.n = add_sum[MSB];
            flg_d.z = (add_sum == '0);
            en_d    = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
         end
         OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
            res_d   = bit_res;
            we_d    = 1'b1;
            flg_d.n = bit_res[MSB];
            flg_d.z = (bit_res == '0);
            flg_d.c = bit_co;
            en_d    = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
         end
         default: ;
      endcase
   end

   acc_alu_stage #(.WIDTH(WIDTH)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (in_valid),
      .res_d (res_d),
      .we_d  (we_d),
      .flg_d (flg_d),
      .en_d  (en_d),
      .res_q (out_res),
      .we_q  (out_we),
      .flg_q (flg_q),
      .en_q  (en_q)
   );

   assign out_n = flg_q.n;
   assign out_v = flg_q.v;
   assign out_z = flg_q.z;
   assign out_c = flg_q.c;
   assign en_n  = en_q.n;
   assign en_v  = en_q.v;
   assign en_z  = en_q.z;
   assign en_c  = en_q.c;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [3:0]       op,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_m,
   input logic             flag_v,
   input logic             flag_c,
   input logic             flag_d,
   input logic [WIDTH-1:0] out_res,
   input logic             out_we,
   input logic             out_n,
   input logic             out_v,
   input logic             out_c,
   input logic             en_n,
   input logic             en_v,
   input logic             en_z,
   input logic             en_c
);

   localparam int MSB = WIDTH - 1;

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_we && !en_n && !en_v && !en_z && !en_c));

   p_logic_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op <= 4'd2) |=> (out_we && en_n && en_z && !en_v && !en_c));

   p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd5) |=> (!out_we && !en_v && out_c == ($past(opnd_a) >= $past(opnd_m))));

   p_bit_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd6) |=> (!out_we && !en_c && out_n == $past(opnd_m[MSB])
                                    && out_v == $past(opnd_m[MSB-1])));

   p_inc_keeps_vc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd7) |=> (out_v == $past(flag_v) && out_c == $past(flag_c)));

   p_shl_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd9) |=> (out_c == $past(opnd_m[MSB]) && !out_res[0]));

   p_rol_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd11) |=> (out_res[0] == $past(flag_c)));

   p_dec_flag_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && flag_d && op == 4'd3) |=>
         (out_res == WIDTH'($past(opnd_a) + $past(opnd_m) + {{(WIDTH-1){1'b0}}, $past(flag_c)})));

   p_spare_codes_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op >= 4'd13) |=> (!out_we && !en_n && !en_v && !en_z && !en_c));

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op       (op),
   .opnd_a   (opnd_a),
   .opnd_m   (opnd_m),
   .flag_v   (flag_v),
   .flag_c   (flag_c),
   .flag_d   (flag_d),
   .out_res  (out_res),
   .out_we   (out_we),
   .out_n    (out_n),
   .out_v    (out_v),
   .out_c    (out_c),
   .en_n     (en_n),
   .en_v     (en_v),
   .en_z     (en_z),
   .en_c     (en_c)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] opnd_a = '0;
   logic [7:0] opnd_m = '0;
   logic       flag_n = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_d = 1'b0;
   logic [7:0] out_res;
   logic       out_we, out_n, out_v, out_z, out_c, en_n, en_v, en_z, en_c;

   int compared = 0;
   int mismatched = 0;
   logic [15:0] lfsr = 16'hACE1;

   acc_alu #(.WIDTH(8), .RIPPLE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_m(opnd_m),
      .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .flag_d(flag_d),
      .out_res(out_res), .out_we(out_we),
      .out_n(out_n), .out_v(out_v), .out_z(out_z), .out_c(out_c),
      .en_n(en_n), .en_v(en_v), .en_z(en_z), .en_c(en_c)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] corner(input int i);
      case (i)
         0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h3F;
         4: return 8'h40;  5: return 8'h41;  6: return 8'h7E;  7: return 8'h7F;
         8: return 8'h80;  9: return 8'h81; 10: return 8'hBF; 11: return 8'hC0;
        12: return 8'hFE; 13: return 8'hFF; 14: return 8'h55; default: return 8'hAA;
      endcase
   endfunction

   function automatic int sx(input int x);
      return (x >= 128) ? x - 256 : x;
   endfunction

   function automatic string tag_of(input int o);
      if (o <= 2) return "R3";
      if (o == 3) return "R4";
      if (o == 4) return "R5";
      if (o == 5) return "R6";
      if (o == 6) return "R7";
      if (o <= 8) return "R8";
      if (o <= 10) return "R9";
      if (o <= 12) return "R10";
      return "R13";
   endfunction

   // Reference: packs {we, res[7:0], n, v, z, c, en_n, en_v, en_z, en_c}.
   function automatic logic [16:0] model(input int o, input int a, input int m,
                                         input int c, input int fn, input int fv, input int fz);
      int r = 0, we = 0, n = fn, v = fv, z = fz, cc = c;
      int e_n = 0, e_v = 0, e_z = 0, e_c = 0, t, s;
      case (o)
         0, 1, 2: begin
            r = (o == 0) ? (a | m) : (o == 1) ? (a & m) : (a ^ m);
            we = 1; e_n = 1; e_z = 1;
         end
         3: begin
            t = a + m + c; r = t % 256; cc = (t > 255);
            s = sx(a) + sx(m) + c; v = (s > 127 || s < -128);
            we = 1; e_n = 1; e_v = 1; e_z = 1; e_c = 1;
         end
         4: begin
            t = a + (255 - m) + c; r = t % 256; cc = (t > 255);
            s = sx(a) - sx(m) - (1 - c); v = (s > 127 || s < -128);
            we = 1; e_n = 1; e_v = 1; e_z = 1; e_c = 1;
         end
         5: begin
            t = (a - m + 256) % 256; cc = (a >= m);
            n = (t >= 128); z = (t == 0); e_n = 1; e_z = 1; e_c = 1;
         end
         6: begin
            n = (m / 128) % 2; v = (m / 64) % 2; z = ((a & m) == 0);
            e_n = 1; e_v = 1; e_z = 1;
         end
         7, 8: begin
            r = (o == 7) ? (m + 1) % 256 : (m + 255) % 256;
            we = 1; e_n = 1; e_z = 1;
         end
         9, 11: begin
            r = (m * 2 + ((o == 11) ? c : 0)) % 256; cc = (m >= 128);
            we = 1; e_n = 1; e_z = 1; e_c = 1;
         end
         10, 12: begin
            r = m / 2 + ((o == 12) ? c * 128 : 0); cc = m % 2;
            we = 1; e_n = 1; e_z = 1; e_c = 1;
         end
         default: ;
      endcase
      if (we == 1) begin
         n = (r >= 128); z = (r == 0);
      end
      return {we[0], r[7:0], n[0], v[0], z[0], cc[0], e_n[0], e_v[0], e_z[0], e_c[0]};
   endfunction

   function automatic logic [16:0] observed();
      return {out_we, out_res, out_n, out_v, out_z, out_c, en_n, en_v, en_z, en_c};
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   // Drive one operation at a falling edge, compare after the next rising edge.
   task automatic run_op(input int o, input logic [7:0] a, input logic [7:0] m,
                         input logic c, input logic d);
      logic [16:0] exp, act;
      string tag;
      step_lfsr();
      in_valid = 1'b1; op = o[3:0]; opnd_a = a; opnd_m = m;
      flag_c = c; flag_d = d;
      flag_n = lfsr[0]; flag_v = lfsr[1]; flag_z = lfsr[2];
      exp = model(o, int'(a), int'(m), int'(c), int'(flag_n), int'(flag_v), int'(flag_z));
      @(negedge clk);
      act = observed();
      if (exp[16] == 1'b0) act[15:8] = exp[15:8];   // result not defined without a write
      tag = tag_of(o);
      if (d) tag = {tag, "+R12"};
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s (unenabled flags follow inputs, R11) op=%0d a=%02h m=%02h c=%0b: actual %05h expected %05h",
                  tag, o, a, m, c, act, exp);
      end
   endtask

   initial begin
      #4000000;
      mismatched++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      compared++;
      if (observed() !== 17'h0) begin
         mismatched++;
         $display("FAIL R1 reset: actual %05h expected 00000", observed());
      end
      rst_n = 1'b1;
      @(negedge clk);
      compared++;
      if (observed() !== 17'h0) begin
         mismatched++;
         $display("FAIL R1 after reset release: actual %05h expected 00000", observed());
      end

      // Corner sweep over all codes, both carries, decimal flag toggled (R12).
      for (int o = 0; o < 16; o++)
         for (int ai = 0; ai < 16; ai++)
            for (int mi = 0; mi < 16; mi++)
               for (int c = 0; c < 2; c++)
                  run_op(o, corner(ai), corner(mi), c[0], logic'((ai + mi + c) % 2));

      // R2: an idle cycle clears write and enables.
      in_valid = 1'b0;
      @(negedge clk);
      compared++;
      if ({out_we, en_n, en_v, en_z, en_c} !== 5'b0) begin
         mismatched++;
         $display("FAIL R2 idle: actual %05b expected 00000", {out_we, en_n, en_v, en_z, en_c});
      end

      // Pseudo-random operands.
      for (int k = 0; k < 3000; k++) begin
         step_lfsr();
         run_op(int'(lfsr[3:0]), lfsr[11:4], {lfsr[7:0] ^ lfsr[15:8]}, lfsr[12], lfsr[13]);
      end

      in_valid = 1'b0;
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule